// File: doc/BRIEF.md
# Upper-Memory Shadow Routing Decoder

This block sits in a host bridge and decides where each access to the legacy upper-memory window goes. Each access carries a 20-bit physical address and a read/write flag. The access goes either to internal main memory (DRAM) or out to the external expansion/ROM bus. The window covers 0xC0000 to 0xFFFFF. The top 64 KB system area has one 2-bit attribute. The range 0xC0000 to 0xEFFFF is cut into twelve 16 KB segments, and each segment has its own 2-bit attribute. Everything below 0xC0000 always goes to DRAM.

Reads and writes are steered independently. Bit 0 of an attribute selects where reads go, and bit 1 selects where writes go. With this split, firmware can copy ROM into DRAM by reading externally and writing internally. It can then switch reads to DRAM and leave writes external, which write-protects the copy. Seven 8-bit attribute registers are loaded through a simple write port. The routing decision is registered, so it appears one cycle after the access is presented.

Top module: `umem_route`

## Requirements
- R1: After reset every attribute is 0. With attribute 0, every window access routes external, `shadow_enable` is low, and both route outputs are low.
- R2: The cycle after `acc_valid` is sampled high, exactly one of `route_dram` and `route_ext` is high. The cycle after `acc_valid` is low, both are low.
- R3: An access to an address below 0xC0000 routes to DRAM, whatever the attribute registers hold.
- R4: For a read, attribute bit 0 set means DRAM and clear means external. For a write, attribute bit 1 set means DRAM and clear means external.
- R5: Accesses to 0xF0000 through 0xFFFFF use register 0 bits [5:4] as their attribute.
- R6: For n from 1 to 6, register n bits [1:0] govern the 16 KB segment at 0xC0000 + (2n-2)·0x4000. Bits [5:4] of the same register govern the segment that follows it.
- R7: Register bits [3:2] and [7:6] have no effect on routing. Register 0 bits [3:0] also have no effect.
- R8: A register write takes effect for accesses presented on the following cycle. An access presented in the same cycle as the write uses the old value. A write with `cfg_sel` = 7 changes nothing.
- R9: When parameter `SEG2_EN` is 0, writes to register 2 are ignored, and 0xC8000 through 0xCFFFF always route external.
- R10: `shadow_enable` equals register 0 bit 4 and follows a write to register 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Attribute register write strobe |
| cfg_sel | input | 3 | Attribute register index (0 to 6) |
| cfg_wdata | input | 8 | Attribute register write data |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | 20 | Physical address of the access |
| route_dram | output | 1 | Registered: the access goes to internal DRAM |
| route_ext | output | 1 | Registered: the access goes to the external bus |
| shadow_enable | output | 1 | Reads of the 64 KB system area come from DRAM |

## Verification
The hardest condition to bring about is a mixed attribute in one nibble of a register while its neighbour nibble holds a different value. A mapping slip such as a swapped nibble or a register offset by one only shows up in that case. The bench sweeps every attribute value through every nibble of every register. After each write it probes the first and last byte of all twelve segments, the system area and a low address, for both directions. It does the same with only the ignored bits set. A second instance built with register 2 disabled runs the same stimulus, and a same-cycle write-plus-access is staged to expose the one-cycle update rule.

// File: rtl/umem_route.sv
module umem_route #(
  parameter bit SEG2_EN = 1'b1,
  parameter int NREG    = 7,
  parameter int ADDR_W  = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [$clog2(NREG)-1:0] cfg_sel,
  input  logic [7:0]              cfg_wdata,
  input  logic                    acc_valid,
  input  logic                    acc_write,
  input  logic [ADDR_W-1:0]       acc_addr,
  output logic                    route_dram,
  output logic                    route_ext,
  output logic                    shadow_enable
);
  localparam int SEL_W = $clog2(NREG);

  logic [NREG*8-1:0] attr_flat;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 2 && !SEG2_EN) begin : g_off
      assign attr_flat[i*8 +: 8] = 8'h00;
    end else begin : g_on
      logic [7:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          q <= 8'h00;
        else if (cfg_we && cfg_sel == SEL_W'(i))
          q <= cfg_wdata;
      end
      assign attr_flat[i*8 +: 8] = q;
    end
  end

  wire       in_sys = acc_addr[ADDR_W-1 -: 4] == 4'hF;
  wire       in_exp = acc_addr[ADDR_W-1 -: 2] == 2'b11 && acc_addr[ADDR_W-3 -: 2] != 2'b11;
  wire [3:0] seg    = acc_addr[ADDR_W-3 -: 4];
  wire [2:0] ridx   = seg[3:1] + 3'd1;
  wire [7:0] rval   = attr_flat[{ridx, 3'b000} +: 8];
  wire [1:0] nib    = seg[0] ? rval[5:4] : rval[1:0];

  logic [1:0] attr_cur;
  always_comb begin
    if (in_sys)      attr_cur = attr_flat[5:4];
    else if (in_exp) attr_cur = nib;
    else             attr_cur = 2'b11;
  end

  wire go_dram = acc_write ? attr_cur[1] : attr_cur[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      route_dram <= 1'b0;
      route_ext  <= 1'b0;
    end else begin
      route_dram <= acc_valid & go_dram;
      route_ext  <= acc_valid & ~go_dram;
    end
  end

  assign shadow_enable = attr_flat[4];
endmodule

module umem_route_chk #(
  parameter bit SEG2_EN = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [2:0]  cfg_sel,
  input logic [7:0]  cfg_wdata,
  input logic        acc_valid,
  input logic        acc_write,
  input logic [19:0] acc_addr,
  input logic        route_dram,
  input logic        route_ext,
  input logic        shadow_enable
);
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> (route_dram ^ route_ext));

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!route_dram && !route_ext));

  p_low_dram_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_addr < 20'hC0000) |=> route_dram);

  p_shadow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 3'd0) |=> (shadow_enable == $past(cfg_wdata[4])));

  p_seg2_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!SEG2_EN && acc_valid && acc_addr[19:15] == 5'b11001) |=> route_ext);
endmodule

bind umem_route umem_route_chk #(.SEG2_EN(SEG2_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_addr(acc_addr), .route_dram(route_dram), .route_ext(route_ext),
  .shadow_enable(shadow_enable)
);

// File: tb/umem_route_bench.sv
module umem_route_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [19:0] acc_addr = '0;
  logic        a_dram, a_ext, a_sh, b_dram, b_ext, b_sh;

  int errors = 0;
  int checks = 0;
  logic [7:0] m [7];

  always #4 clk = ~clk;

  umem_route u_umem_route (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .route_dram(a_dram), .route_ext(a_ext),
    .shadow_enable(a_sh));

  umem_route #(.SEG2_EN(1'b0)) u_nopair2 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .route_dram(b_dram), .route_ext(b_ext),
    .shadow_enable(b_sh));

  task automatic chk(input logic [1:0] act, input logic [1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic bit exp_dram(input logic [19:0] a, input bit w, input bit no2);
    logic [1:0] at;
    int r;
    if (a[19:16] == 4'hF) at = m[0][5:4];
    else if (a[19:18] == 2'b11 && a[17:16] != 2'b11) begin
      r = int'(a[17:15]) + 1;
      if (no2 && r == 2) at = 2'b00;
      else at = a[14] ? m[r][5:4] : m[r][1:0];
    end else at = 2'b11;
    return w ? at[1] : at[0];
  endfunction

  task automatic cfg(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel < 3'd7) m[sel] = d;
  endtask

  task automatic access(input logic [19:0] a, input bit w, input string tag);
    bit ea, eb;
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_write = w;
    @(negedge clk);
    acc_valid = 1'b0;
    ea = exp_dram(a, w, 1'b0);
    eb = exp_dram(a, w, 1'b1);
    chk({a_dram, a_ext}, {ea, ~ea}, $sformatf("%s addr=%h wr=%0d", tag, a, w));
    chk({b_dram, b_ext}, {eb, ~eb}, $sformatf("R9 %s addr=%h wr=%0d", tag, a, w));
  endtask

  task automatic sweep(input string tag);
    for (int s = 0; s < 12; s++) begin
      for (int w = 0; w < 2; w++) begin
        access(20'hC0000 + 20'(s) * 20'h4000, w[0], tag);
        access(20'hC3FFF + 20'(s) * 20'h4000, w[0], tag);
      end
    end
    for (int w = 0; w < 2; w++) begin
      access(20'hF0000, w[0], tag);
      access(20'hFFFFF, w[0], tag);
      access(20'h9A5A5, w[0], {tag, " R3"});
    end
    chk({a_sh, b_sh}, {m[0][4], m[0][4]}, {tag, " R10 shadow"});
  endtask

  task automatic t_reset;
    chk({a_dram, a_ext}, 2'b00, "R1 route idle after reset");
    chk({a_sh, b_sh}, 2'b00, "R1 shadow low after reset");
    @(negedge clk);
    chk({a_dram, a_ext}, 2'b00, "R2 idle with no strobe");
    sweep("R1 reset routing");
  endtask

  task automatic t_low;
    for (int r = 0; r < 7; r++) cfg(3'(r), 8'h00);
    access(20'h00000, 1'b0, "R3 low");
    access(20'hBFFFF, 1'b1, "R3 low edge");
    access(20'hBFFFF, 1'b0, "R3 low edge");
  endtask

  task automatic t_sys;
    for (int v = 0; v < 4; v++) begin
      cfg(3'd0, 8'(v << 4));
      sweep("R4 R5 sys");
    end
  endtask

  task automatic t_segs;
    for (int r = 1; r < 7; r++) begin
      for (int v = 0; v < 4; v++) begin
        cfg(3'(r), 8'(v | ((3 - v) << 4)));
        sweep("R4 R6 seg");
      end
      cfg(3'(r), 8'h00);
    end
  endtask

  task automatic t_upper;
    for (int r = 0; r < 7; r++) cfg(3'(r), 8'hCC);
    sweep("R7 upper bits only");
    cfg(3'd0, 8'h0F);
    sweep("R7 reg0 low nibble");
    for (int r = 0; r < 7; r++) cfg(3'(r), 8'hE6);
    sweep("R7 mixed");
  endtask

  task automatic t_sel7;
    for (int r = 0; r < 7; r++) cfg(3'(r), 8'h00);
    cfg(3'd7, 8'hFF);
    sweep("R8 sel7 ignored");
  endtask

  task automatic t_timing;
    cfg(3'd1, 8'h00);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'd1; cfg_wdata = 8'h03;
    acc_valid = 1'b1; acc_addr = 20'hC0000; acc_write = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; acc_valid = 1'b0;
    chk({a_dram, a_ext}, 2'b01, "R8 same-cycle access uses old value");
    m[1] = 8'h03;
    access(20'hC0000, 1'b0, "R8 next access uses new value");
    access(20'hC0000, 1'b1, "R8 next access uses new value");
  endtask

  initial begin
    for (int r = 0; r < 7; r++) m[r] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_low();
    t_sys();
    t_segs();
    t_upper();
    t_sel7();
    t_timing();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule